// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block sits between a 32-bit processor bus and a system whose targets are either 32 or 16 bits wide. The processor starts a transfer with a one-cycle start strobe. The strobe carries a direction, a transfer size and the two low address bits. The controller works out which byte lanes the operand covers and runs one or more target cycles to move it. During each target cycle it presents the lanes still outstanding, an address bit A1 and steered write data. It samples the width of the addressed port together with each target acknowledge.

A 32-bit port finishes the transfer in one target cycle. A 16-bit port sits on the upper half of the data bus. For that port the controller runs one target cycle per 16-bit half that the operand touches. It moves the write half onto the upper lanes, and it gathers each read half back into its natural position. Only when every byte has moved does it give the processor a one-cycle acknowledge, with the assembled read word. A target error on any cycle ends the sequence at once and is reported instead of the acknowledge.

Top module: `dyn_bus_sizer`

## Requirements
- R1: After reset, cpu_ack, cpu_err, tgt_cycle and tgt_start are low and cpu_rdata is zero.
- R2: Byte offset o within the long word maps to lane 3-o, which is bits 8*(3-o)+7 down to 8*(3-o). cpu_siz 01 is a byte, 10 is a word, and 00 or 11 is a long word. The operand covers offsets from cpu_addr up to cpu_addr+length-1, and offsets beyond 3 are dropped. The first target cycle presents exactly this lane set on tgt_be.
- R3: When the target acknowledges with tgt_port16 low, the transfer ends in that single target cycle. cpu_ack is high for one cycle, in the cycle after the acknowledge edge.
- R4: With tgt_port16 high, a long word at offset 0 runs two target cycles. The first has tgt_a1 = 0 and the second has tgt_a1 = 1. cpu_ack follows the second acknowledge only.
- R5: On a 16-bit port, one target cycle runs for each half that holds operand bytes. The upper half is lanes 3..2 with tgt_a1 = 0, and the lower half is lanes 1..0 with tgt_a1 = 1. The upper half goes first. A second cycle presents only lanes 1..0 of the operand on tgt_be, so byte and word operands that fit in one half finish on the first acknowledge.
- R6: The read result holds the operand's lanes and zero in every other lane. On a 32-bit port the data is taken in place. On a 16-bit port each cycle's data is taken from bits 31..16 and placed at its own half.
- R7: In every target cycle, tgt_wdata[31:16] carries cpu_wdata[31:16] when tgt_a1 = 0 and cpu_wdata[15:0] when tgt_a1 = 1. tgt_wdata[15:0] always carries cpu_wdata[15:0].
- R8: tgt_err during a target cycle, with or without tgt_ack, ends the sequence. In the next cycle cpu_err is high for one cycle, cpu_ack stays low and tgt_cycle is low.
- R9: cpu_ts while a sequence is running is ignored: the running transfer's lanes, cycle count and result are unchanged.
- R10: tgt_start is high only in the first cycle of each target cycle. cpu_rdata is cleared when a transfer is accepted and holds its value after cpu_ack until the next accepted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_ts | input | 1 | Transfer start strobe, one cycle |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_siz | input | 2 | Transfer size (see R2) |
| cpu_addr | input | 2 | Low address bits A1..A0 |
| cpu_wdata | input | 32 | Write data, in place on its lanes |
| cpu_ack | output | 1 | Transfer complete, one cycle |
| cpu_err | output | 1 | Transfer aborted by target error, one cycle |
| cpu_rdata | output | 32 | Assembled read word |
| tgt_cycle | output | 1 | A target cycle is in progress |
| tgt_start | output | 1 | First cycle of a target cycle |
| tgt_a1 | output | 1 | Address bit A1 for the current target cycle |
| tgt_be | output | 4 | Outstanding byte lanes, bit i = lane i |
| tgt_wdata | output | 32 | Steered write data |
| tgt_port16 | input | 1 | Addressed port is 16 bits wide when high |
| tgt_ack | input | 1 | Target acknowledge, sampled on the rising edge |
| tgt_err | input | 1 | Target error acknowledge |
| tgt_rdata | input | 32 | Read data from the target |

## Verification
The bench builds the block with its default four lanes of eight bits, the widths it is built for. That keeps the whole space small enough to sweep exhaustively: every size code at every offset, for both port widths and both directions. Each sweep point runs with several acknowledge latencies. Error acknowledges are placed on the first and on the second half cycle, and a start strobe is injected in the middle of a sequence.

// File: rtl/sizer_pkg.sv
package sizer_pkg;
    localparam int BYTE_W     = 8;
    localparam int LANES      = 4;
    localparam int DATA_W     = BYTE_W * LANES;
    localparam int HALF_LANES = LANES / 2;
    localparam int HALF_W     = DATA_W / 2;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    typedef logic [LANES-1:0] lane_mask_t;

    typedef struct packed {
        logic              busy;
        logic              rw;
        lane_mask_t        rem;
        logic [DATA_W-1:0] wdata;
        logic              start;
        logic              ack;
        logic              err;
    } seq_state_t;
endpackage

// File: rtl/sizer_lane_mask.sv
module sizer_lane_mask
    import sizer_pkg::*;
(
    input  logic [1:0] siz,
    input  logic [1:0] addr,
    output lane_mask_t mask
);
    int unsigned len;

    always_comb begin
        case (xfer_size_e'(siz))
            SZ_BYTE: len = 1;
            SZ_WORD: len = 2;
            default: len = LANES;
        endcase
        for (int o = 0; o < LANES; o++) begin
            mask[LANES-1-o] = (o >= int'(addr)) && (o < int'(addr) + int'(len));
        end
    end
endmodule

// File: rtl/sizer_steer.sv
module sizer_steer
    import sizer_pkg::*;
(
    input  logic              cur_word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tgt_wdata
);
    always_comb begin
        tgt_wdata[HALF_W-1:0]      = wdata[HALF_W-1:0];
        tgt_wdata[DATA_W-1:HALF_W] = cur_word ? wdata[HALF_W-1:0] : wdata[DATA_W-1:HALF_W];
    end
endmodule

// File: rtl/sizer_gather.sv
module sizer_gather
    import sizer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic              narrow,
    input  logic              cur_word,
    input  lane_mask_t        rem,
    input  logic [DATA_W-1:0] tgt_rdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_d, rd_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int  SRC  = (i % HALF_LANES) + HALF_LANES;
        localparam bit  WORD = (i < HALF_LANES);
        logic take;
        always_comb begin
            take = capture && rem[i] && (!narrow || (cur_word == WORD));
            if (clear) begin
                rd_d[i*BYTE_W +: BYTE_W] = '0;
            end else if (take) begin
                rd_d[i*BYTE_W +: BYTE_W] = narrow ? tgt_rdata[SRC*BYTE_W +: BYTE_W]
                                                  : tgt_rdata[i*BYTE_W +: BYTE_W];
            end else begin
                rd_d[i*BYTE_W +: BYTE_W] = rd_q[i*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;

    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rdata == '0));
endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
    import sizer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ts,
    input  logic              cpu_rw,
    input  logic [1:0]        cpu_siz,
    input  logic [1:0]        cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic              cpu_err,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              tgt_cycle,
    output logic              tgt_start,
    output logic              tgt_a1,
    output logic [LANES-1:0]  tgt_be,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic              tgt_port16,
    input  logic              tgt_ack,
    input  logic              tgt_err,
    input  logic [DATA_W-1:0] tgt_rdata
);
    seq_state_t s_d, s_q;
    lane_mask_t req_mask, word_lanes, next_rem;
    logic       cur_word, accept, step, capture;

    sizer_lane_mask u_mask (
        .siz  (cpu_siz),
        .addr (cpu_addr),
        .mask (req_mask)
    );

    assign cur_word   = (s_q.rem[LANES-1:HALF_LANES] == '0);
    assign word_lanes = cur_word ? lane_mask_t'({HALF_LANES{1'b1}})
                                 : lane_mask_t'({{HALF_LANES{1'b1}}, {HALF_LANES{1'b0}}});
    assign accept     = !s_q.busy && cpu_ts;
    assign step       = s_q.busy && (tgt_ack || tgt_err);
    assign capture    = step && !tgt_err && s_q.rw;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.ack   = 1'b0;
        s_d.err   = 1'b0;
        next_rem  = tgt_port16 ? (s_q.rem & ~word_lanes) : '0;
        if (accept) begin
            s_d.busy  = 1'b1;
            s_d.rw    = cpu_rw;
            s_d.rem   = req_mask;
            s_d.wdata = cpu_wdata;
            s_d.start = 1'b1;
        end else if (step) begin
            if (tgt_err) begin
                s_d.busy = 1'b0;
                s_d.rem  = '0;
                s_d.err  = 1'b1;
            end else begin
                s_d.rem = next_rem;
                if (next_rem == '0) begin
                    s_d.busy = 1'b0;
                    s_d.ack  = 1'b1;
                end else begin
                    s_d.start = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    sizer_steer u_steer (
        .cur_word  (cur_word),
        .wdata     (s_q.wdata),
        .tgt_wdata (tgt_wdata)
    );

    sizer_gather u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (capture),
        .narrow    (tgt_port16),
        .cur_word  (cur_word),
        .rem       (s_q.rem),
        .tgt_rdata (tgt_rdata),
        .rdata     (cpu_rdata)
    );

    assign cpu_ack   = s_q.ack;
    assign cpu_err   = s_q.err;
    assign tgt_cycle = s_q.busy;
    assign tgt_start = s_q.start;
    assign tgt_a1    = cur_word;
    assign tgt_be    = s_q.rem;

    a_r3_ack_follows_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> $past(tgt_ack && tgt_cycle && !tgt_err));
    a_r3_wide_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_cycle && tgt_ack && !tgt_err && !tgt_port16) |=> (cpu_ack && !tgt_cycle));
    a_r8_err_follows_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> $past(tgt_err && tgt_cycle));
    a_r8_ack_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ack && cpu_err));
    a_r2_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_cycle |-> (tgt_be != '0));
    a_r9_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_cycle && !tgt_ack && !tgt_err) |=> (tgt_cycle && $stable(tgt_be) && !tgt_start));
    a_r4_a1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_cycle && tgt_ack && !tgt_err && tgt_port16 && !tgt_a1 && (tgt_be[HALF_LANES-1:0] != '0))
        |=> (tgt_cycle && tgt_a1 && tgt_start));
endmodule

// File: tb/sim_dyn_bus_sizer.sv
`timescale 1ns/1ps
module sim_dyn_bus_sizer;
    logic        clk = 0, rst_n = 0;
    logic        cpu_ts = 0, cpu_rw = 0;
    logic [1:0]  cpu_siz = 0, cpu_addr = 0;
    logic [31:0] cpu_wdata = 0;
    logic        cpu_ack, cpu_err, tgt_cycle, tgt_start, tgt_a1;
    logic [31:0] cpu_rdata, tgt_wdata;
    logic [3:0]  tgt_be;
    logic        tgt_port16 = 0, tgt_ack = 0, tgt_err = 0;
    logic [31:0] tgt_rdata = 0;

    int checks = 0, errors = 0;
    bit reported = 0;

    always #2 clk = ~clk;

    dyn_bus_sizer u0 (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    function automatic logic [3:0] exp_mask(input logic [1:0] siz, input logic [1:0] adr);
        int len;
        logic [3:0] m;
        len = (siz == 2'b01) ? 1 : (siz == 2'b10) ? 2 : 4;
        m = 0;
        for (int o = 0; o < 4; o++)
            if (o >= int'(adr) && o < int'(adr) + len) m[3-o] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] lanes(input logic [3:0] m);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = m[i] ? 8'hFF : 8'h00;
        return r;
    endfunction

    task automatic xfer(input logic [1:0] siz, input logic [1:0] adr, input bit rw, input bit p16,
                        input int lat, input int err_at, input bit extra_ts, input logic [31:0] mem,
                        input logic [31:0] wd);
        logic [3:0] m, be_exp;
        int nsub, sub;
        bit done, a1_exp;
        string tg;
        m = exp_mask(siz, adr);
        nsub = p16 ? (((m[3:2] != 0) ? 1 : 0) + ((m[1:0] != 0) ? 1 : 0)) : 1;
        @(negedge clk);
        cpu_ts = 1; cpu_siz = siz; cpu_addr = adr; cpu_rw = rw; cpu_wdata = wd; tgt_port16 = p16;
        @(negedge clk);
        cpu_ts = 0;
        sub = 0; done = 0;
        while (!done && sub < 6) begin
            be_exp = (sub == 0) ? m : (m & 4'b0011);
            a1_exp = (be_exp[3:2] == 0);
            tg = (sub == 0) ? "R2 first lanes" : "R5 second lanes";
            check(tgt_cycle === 1'b1, "R5 cycle active", {31'b0, tgt_cycle}, 1);
            check(tgt_start === 1'b1, "R10 start pulse", {31'b0, tgt_start}, 1);
            check(tgt_be === be_exp, tg, {28'b0, tgt_be}, {28'b0, be_exp});
            check(tgt_a1 === a1_exp, (p16 && m == 4'hF) ? "R4 a1 order" : "R5 a1", {31'b0, tgt_a1}, {31'b0, a1_exp});
            if (!rw)
                check(tgt_wdata === {(a1_exp ? wd[15:0] : wd[31:16]), wd[15:0]}, "R7 write steer",
                      tgt_wdata, {(a1_exp ? wd[15:0] : wd[31:16]), wd[15:0]});
            if (extra_ts && sub == 0) begin
                cpu_ts = 1; cpu_siz = 2'b01; cpu_addr = 2'b11;
            end
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                cpu_ts = 0;
                check(tgt_start === 1'b0 && tgt_cycle === 1'b1, "R10 start one cycle", {30'b0, tgt_start, tgt_cycle}, 1);
            end
            tgt_ack = (err_at == sub) ? (sub[0]) : 1'b1;
            tgt_err = (err_at == sub);
            tgt_rdata = p16 ? {(tgt_a1 ? mem[15:0] : mem[31:16]), 16'hBEEF} : mem;
            @(negedge clk);
            tgt_ack = 0; tgt_err = 0; cpu_ts = 0;
            tgt_rdata = 32'h5A5A_5A5A;
            sub++;
            if (cpu_ack || cpu_err || !tgt_cycle) done = 1;
        end
        if (err_at >= 0) begin
            check(cpu_err === 1'b1 && cpu_ack === 1'b0, "R8 error reported", {30'b0, cpu_err, cpu_ack}, 2);
            check(tgt_cycle === 1'b0, "R8 cycle ended", {31'b0, tgt_cycle}, 0);
            check(sub == err_at + 1, "R8 abort count", sub, err_at + 1);
        end else begin
            check(cpu_ack === 1'b1 && cpu_err === 1'b0, p16 ? "R4 ack after all" : "R3 single ack",
                  {30'b0, cpu_ack, cpu_err}, 2);
            check(sub == nsub, extra_ts ? "R9 ignored start" : (p16 ? "R5 cycle count" : "R3 cycle count"), sub, nsub);
            if (rw) check(cpu_rdata === (mem & lanes(m)), extra_ts ? "R9 result" : "R6 read assembly",
                          cpu_rdata, mem & lanes(m));
        end
        @(negedge clk);
        check(cpu_ack === 1'b0 && cpu_err === 1'b0, "R3 ack one cycle", {30'b0, cpu_ack, cpu_err}, 0);
        if (rw && err_at < 0)
            check(cpu_rdata === (mem & lanes(m)), "R10 rdata hold", cpu_rdata, mem & lanes(m));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cpu_ack === 0 && cpu_err === 0 && tgt_cycle === 0 && tgt_start === 0,
              "R1 reset outputs", {28'b0, cpu_ack, cpu_err, tgt_cycle, tgt_start}, 0);
        check(cpu_rdata === 32'h0, "R1 reset rdata", cpu_rdata, 0);
        rst_n = 1;
        @(negedge clk);
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 4; a++)
                for (int p = 0; p < 2; p++)
                    for (int r = 0; r < 2; r++)
                        xfer(2'(s), 2'(a), r[0], p[0], (s + a + p) % 3, -1, 0,
                             32'hA1B2C3D4 ^ (32'h01010101 * (s * 8 + a * 2 + p)),
                             32'h1F2E3D4C + 32'h11111111 * (a + s));
        xfer(2'b00, 2'b00, 1, 1, 1, 0, 0, 32'hCAFEF00D, 0);
        xfer(2'b00, 2'b00, 1, 1, 0, 1, 0, 32'hCAFEF00D, 0);
        xfer(2'b10, 2'b10, 0, 0, 2, 0, 0, 0, 32'h01234567);
        xfer(2'b00, 2'b00, 1, 1, 1, -1, 1, 32'h89ABCDEF, 0);
        xfer(2'b00, 2'b00, 1, 0, 0, -1, 1, 32'h76543210, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog act=%h exp=%h", 1, 0);
        summary();
        $finish;
    end
endmodule